// File: doc/BRIEF.md
# One-Shot Temperature Conversion Controller

This block sequences exactly one temperature reading from an on-die sensing converter. A fast system clock (up to 80 MHz) is divided by a design-time ratio into a slow conversion cadence of 1 MHz or less. The divided clock is delivered as a one-cycle tick in the system-clock domain. After ten ticks, the block captures the 8-bit code presented by the sensor front end and raises a done flag. From then on it holds that result until a clear or a reset starts a new measurement.

Until the reading completes, the result output carries the sentinel code 0xD5 rather than zero. The enable input gates the divider. Lowering enable pauses the conversion and freezes the outputs without clearing them. Clear takes effect asynchronously. Its release is synchronised before the divider and the cycle counter restart. A parameter removes the enable input's effect, which leaves the converter running whenever it is not cleared.

Top module: `tsense_oneshot`

## Requirements
- R1: While `rst` is high or `clr_async` is high, every rising clock edge leaves `done_o` = 0 and `result_o` = 0xD5.
- R2: While running, `conv_tick_o` is a one-cycle pulse that repeats every `DIV_RATIO` clock cycles. Running means enable is effective and the clear is released.
- R3: `done_o` rises on the clock edge that follows the tenth `conv_tick_o` pulse after a reset or clear release, and never earlier.
- R4: The edge that raises `done_o` loads the value on `sample_i` into `result_o`.
- R5: Once `done_o` is 1, later changes on `sample_i` and later ticks leave `done_o` and `result_o` unchanged.
- R6: While `enable` is 0, no ticks occur and the outputs hold their values. The tick count is kept, so the measurement completes after the remaining ticks once `enable` returns to 1.
- R7: Lowering `enable` after completion keeps `done_o` = 1 and keeps the captured result.
- R8: A clear pulse restarts the measurement. Its release passes a two-stage synchroniser, after which a fresh ten-tick conversion captures the new sample.
- R9: With `HAS_ENABLE` = 0, the `enable` input has no effect and a measurement completes even while it is 0.
- R10: No tick is produced while the clear is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Gates the conversion divider |
| clr_async | input | 1 | Asynchronous clear; restarts the measurement |
| sample_i | input | CODE_W | Raw code from the sensor front end |
| result_o | output | CODE_W | Captured code; 0xD5 until done |
| done_o | output | 1 | High once the measurement is complete |
| conv_tick_o | output | 1 | One-cycle conversion tick |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `clr_async` changes only between edges, so the hold signal it drives is settled at each edge. The bench drives the clear a short delay after a falling edge and asserts reset from time zero. It keeps `sample_i` steady around each completing tick, so the captured code is unambiguous.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int unsigned DEF_CODE_W      = 8;
  localparam int unsigned DEF_CONV_CYCLES = 10;
  localparam logic [7:0]  DEF_SENTINEL    = 8'hD5;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsense_clr_sync.sv
module tsense_clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_async,
  output logic hold_o
);
  logic [STAGES-1:0] stg_q;

  // asserts at once, releases after STAGES clean edges
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)  stg_q <= '1;
    else if (rst)   stg_q <= '1;
    else            stg_q <= {stg_q[STAGES-2:0], 1'b0};
  end

  assign hold_o = stg_q[STAGES-1];

  p_release_ordered_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> !clr_async);
endmodule

// File: rtl/tsense_tick_div.sv
module tsense_tick_div #(
  parameter int unsigned DIV = 80
) (
  input  logic clk,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  import tsense_pkg::*;
  localparam int unsigned CW = cw(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= run_i && (cnt_q == LAST);
      if (run_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  p_tick_single_r2: assert property (@(posedge clk) disable iff (clr_i)
    (DIV > 1 && tick_o) |=> !tick_o);
  p_no_tick_idle_r6: assert property (@(posedge clk) disable iff (clr_i)
    !run_i |=> !tick_o);
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
  parameter int unsigned W        = 8,
  parameter int unsigned N        = 10,
  parameter logic [W-1:0] SENTINEL = '0
) (
  input  logic         clk,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  import tsense_pkg::*;
  localparam int unsigned NW = cw(N);
  localparam logic [NW-1:0] LAST = NW'(N - 1);

  logic [NW-1:0] n_q;
  logic [W-1:0]  res_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      n_q    <= '0;
      res_q  <= SENTINEL;
      done_q <= 1'b0;
    end else if (tick_i && !done_q) begin
      if (n_q == LAST) begin
        done_q <= 1'b1;
        res_q  <= sample_i;
      end else begin
        n_q <= n_q + 1'b1;
      end
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;

  p_done_on_tick_r3: assert property (@(posedge clk) disable iff (clr_i)
    $rose(done_q) |-> $past(tick_i));
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (clr_i)
    done_q |=> done_q);
  p_result_held_r5: assert property (@(posedge clk) disable iff (clr_i)
    done_q |=> $stable(res_q));
  p_freeze_no_tick_r6: assert property (@(posedge clk) disable iff (clr_i)
    !tick_i |=> ($stable(done_q) && $stable(res_q)));
endmodule

// File: rtl/tsense_oneshot.sv
module tsense_oneshot #(
  parameter int unsigned CODE_W      = tsense_pkg::DEF_CODE_W,
  parameter int unsigned DIV_RATIO   = 80,
  parameter int unsigned CONV_CYCLES = tsense_pkg::DEF_CONV_CYCLES,
  parameter int unsigned SYNC_STAGES = tsense_pkg::DEF_SYNC_STAGES,
  parameter logic [CODE_W-1:0] SENTINEL = CODE_W'(tsense_pkg::DEF_SENTINEL),
  parameter bit          HAS_ENABLE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              clr_async,
  input  logic [CODE_W-1:0] sample_i,
  output logic [CODE_W-1:0] result_o,
  output logic              done_o,
  output logic              conv_tick_o
);
  logic hold;
  logic en_eff;
  logic run;
  logic clr_int;

  generate
    if (HAS_ENABLE) begin : g_en
      assign en_eff = enable;
    end else begin : g_noen
      assign en_eff = 1'b1;
    end
  endgenerate

  tsense_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clr_async(clr_async), .hold_o(hold)
  );

  assign clr_int = rst | hold;
  assign run     = en_eff & ~hold;

  tsense_tick_div #(.DIV(DIV_RATIO)) u_div (
    .clk(clk), .clr_i(clr_int), .run_i(run), .tick_o(conv_tick_o)
  );

  tsense_seq #(.W(CODE_W), .N(CONV_CYCLES), .SENTINEL(SENTINEL)) u_seq (
    .clk(clk), .clr_i(clr_int), .tick_i(conv_tick_o), .sample_i(sample_i),
    .result_o(result_o), .done_o(done_o)
  );

  p_clear_presets_r1: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!done_o && result_o == SENTINEL));
  p_no_tick_clear_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> !conv_tick_o);
endmodule

// File: tb/test_tsense_oneshot.sv
module test_tsense_oneshot;
  localparam int DIV = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic clr_async = 1'b0;
  logic [7:0] sample = 8'h00;
  logic [7:0] result;
  logic done, tick;
  logic [7:0] r2;
  logic d2, t2;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tsense_oneshot #(.DIV_RATIO(DIV)) i_tsense_oneshot (
    .clk(clk), .rst(rst), .enable(enable), .clr_async(clr_async),
    .sample_i(sample), .result_o(result), .done_o(done), .conv_tick_o(tick));

  tsense_oneshot #(.DIV_RATIO(DIV), .HAS_ENABLE(1'b0)) i_tsense_noen (
    .clk(clk), .rst(rst), .enable(1'b0), .clr_async(1'b0),
    .sample_i(8'h3C), .result_o(r2), .done_o(d2), .conv_tick_o(t2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // count ticks up to done; returns ticks seen and whether done followed a tick
  task automatic run_to_done(output int ticks, output bit after_tick, output int gap_bad);
    bit prev = 0;
    int last_at = -1;
    ticks = 0; after_tick = 0; gap_bad = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin after_tick = prev; break; end
      if (tick) begin
        if (prev) gap_bad++;
        if (last_at >= 0 && i - last_at != DIV) gap_bad++;
        last_at = i;
        ticks++;
      end
      prev = tick;
    end
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk);
    chk(done == 0, "R1 done in reset", done, 0);
    chk(result == 8'hD5, "R1 result in reset", result, 8'hD5);
    rst = 1'b0;
  endtask

  task automatic t_first_measure;
    int n, gb; bit at;
    sample = 8'h5A;
    run_to_done(n, at, gb);
    chk(n == 10, "R3 ticks before done", n, 10);
    chk(at, "R3 done one edge after tenth tick", at, 1);
    chk(gb == 0, "R2 tick width and period", gb, 0);
    chk(result == 8'h5A, "R4 captured sample", result, 8'h5A);
  endtask

  task automatic t_hold_after_done;
    int nt = 0;
    sample = 8'hA7;
    for (int i = 0; i < 5 * DIV; i++) begin
      @(negedge clk);
      if (tick) nt++;
    end
    chk(nt >= 4, "R5 ticks continue after done", nt, 5);
    chk(done == 1, "R5 done sticky", done, 1);
    chk(result == 8'h5A, "R5 result held", result, 8'h5A);
  endtask

  task automatic t_enable_after_done;
    enable = 1'b0;
    sample = 8'h11;
    repeat (3 * DIV) @(negedge clk);
    chk(done == 1, "R7 done kept with enable low", done, 1);
    chk(result == 8'h5A, "R7 result kept with enable low", result, 8'h5A);
    enable = 1'b1;
  endtask

  task automatic t_clear(input logic [7:0] nv);
    int nt = 0, n, gb; bit at;
    #1 clr_async = 1'b1;
    @(negedge clk);
    chk(done == 0, "R1 done cleared", done, 0);
    chk(result == 8'hD5, "R1 result preset on clear", result, 8'hD5);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (tick) nt++;
    end
    chk(nt == 0, "R10 no tick during clear", nt, 0);
    sample = nv;
    clr_async = 1'b0;
    run_to_done(n, at, gb);
    chk(n == 10 && at, "R8 fresh ten-tick conversion", n, 10);
    chk(result == nv, "R8 new sample captured", result, nv);
  endtask

  task automatic t_enable_pause;
    int n = 0, nt = 0, m, gb; bit at;
    #1 clr_async = 1'b1;
    @(negedge clk);
    clr_async = 1'b0;
    sample = 8'hC3;
    while (n < 4) begin
      @(negedge clk);
      if (tick) n++;
    end
    enable = 1'b0;
    for (int i = 0; i < 6 * DIV; i++) begin
      @(negedge clk);
      if (tick) nt++;
    end
    chk(nt == 0, "R6 no ticks while disabled", nt, 0);
    chk(done == 0, "R6 done frozen", done, 0);
    chk(result == 8'hD5, "R6 result frozen", result, 8'hD5);
    enable = 1'b1;
    run_to_done(m, at, gb);
    chk(m == 6 && at, "R6 remaining ticks after resume", m, 6);
    chk(result == 8'hC3, "R6 capture after resume", result, 8'hC3);
  endtask

  task automatic t_noen;
    chk(d2 == 1, "R9 completes with enable tied low", d2, 1);
    chk(r2 == 8'h3C, "R9 result without enable", r2, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_first_measure();
    t_hold_after_done();
    t_enable_after_done();
    t_clear(8'h27);
    t_enable_pause();
    t_noen();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule